// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog that software arms by writing a single byte. The byte packs three things: a 2-bit resolution field that picks a power-of-four tick scale, a 5-bit multiplier, and a steering bit. Together the two numeric fields give a timeout measured in strobes of a tick-enable input. That input is expected to pulse once every sixteenth of a second. The block does not divide the clock itself.

Every write cancels any countdown in progress and clears the expiry flag. A write with a nonzero interval starts a fresh countdown. A write whose interval works out to zero leaves the watchdog disarmed. When the countdown runs out, the block does one of two things, chosen by the steering bit. It either raises a one-cycle system-reset request, or it raises a one-cycle interrupt pulse and sets a sticky expiry flag. After an expiry the watchdog stays idle until the next write.

Top module: `wdog_prescaled`

## Requirements
- R1: After reset, `sys_rst_req`, `wdt_irq` and `expired_flag` are 0, and no expiry occurs until a nonzero interval is written.
- R2: A written code gives an interval of `cfg_wdata[6:2] * 4**cfg_wdata[1:0]` tick strobes. The expiry output rises in the clock cycle right after the edge that samples the last tick strobe of that interval.
- R3: Any write to the register clears `expired_flag`, which reads 0 in the cycle after the write.
- R4: A code whose multiplier field `cfg_wdata[6:2]` is zero disarms the watchdog for any resolution field, so no expiry follows however many ticks arrive.
- R5: A write during a countdown discards the remaining count and restarts the countdown from the new code's interval.
- R6: With `cfg_wdata[7]`=1 at arming, expiry raises `sys_rst_req` for exactly one cycle. In this mode `wdt_irq` stays 0 and `expired_flag` stays 0.
- R7: With `cfg_wdata[7]`=0 at arming, expiry raises `wdt_irq` for exactly one cycle and sets `expired_flag`. The flag stays 1 until the next write.
- R8: After one expiry, the watchdog produces no further expiry from tick strobes until it is written again.
- R9: Clock cycles without a tick strobe do not advance the countdown.
- R10: A tick strobe in the same cycle as a write is not counted against the new interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; stops any countdown and clears the flag |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Code byte: [1:0] resolution, [6:2] multiplier, [7] steering (1 = reset request) |
| tick | input | 1 | One-cycle strobe at the 1/16 s tick rate |
| sys_rst_req | output | 1 | One-cycle system reset request on expiry in reset mode |
| wdt_irq | output | 1 | One-cycle interrupt pulse on expiry in interrupt mode |
| expired_flag | output | 1 | Sticky expiry flag, set in interrupt mode and cleared by any write |

## Verification
The hardest case to reach is expiry at the largest coded interval, 31 times 64 ticks. Only a long run of tick strobes gets the counter down through its full width. The bench arms the watchdog with the largest code and issues every one of the 1984 strobes. It checks that no pulse appears early and that the pulse comes on the last strobe. A write that lands on the same cycle as a tick is also hard to produce from outside. The bench drives both strobes on the same falling edge to force that collision.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   // What the block does when the countdown runs out
   typedef enum logic {
      ACT_IRQ   = 1'b0,
      ACT_RESET = 1'b1
   } wdog_action_e;

endpackage

// File: rtl/wdog_interval_decode.sv
module wdog_interval_decode #(
   parameter int MULT_W    = 5,
   parameter int RES_W     = 2,
   parameter int CNT_W     = 12,
   parameter bit USE_SHIFT = 1'b1
) (
   input  logic [MULT_W-1:0] mult,
   input  logic [RES_W-1:0]  res,
   output logic [CNT_W-1:0]  ticks,
   output logic              is_zero
);

   localparam int SHAMT_W = RES_W + 1;

   logic [SHAMT_W-1:0] shamt;
   assign shamt = {res, 1'b0};

   generate
      if (USE_SHIFT) begin : g_shift
         // power-of-four scale as a plain left shift
         assign ticks = CNT_W'(mult) << shamt;
      end else begin : g_mul
         logic [CNT_W-1:0] scale;
         assign scale = CNT_W'(1) << shamt;
         assign ticks = CNT_W'(mult) * scale;
      end
   endgenerate

   assign is_zero = (mult == '0);

endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             load_arm,
   input  logic             tick,
   output logic             expire,
   output logic             armed
);

   logic [CNT_W-1:0] count;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         armed <= 1'b0;
      end else if (load) begin
         count <= load_val;
         armed <= load_arm;
      end else if (armed && tick) begin
         if (count == CNT_W'(1)) begin
            count <= '0;
            armed <= 1'b0;
         end else begin
            count <= count - CNT_W'(1);
         end
      end
   end

   assign expire = armed && tick && !load && (count == CNT_W'(1));

   // R2
   armed_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (count != '0));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(count));

   // R8
   disarm_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !armed);

endmodule

// File: rtl/wdog_expiry_route.sv
module wdog_expiry_route
   import wdog_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  wdog_action_e load_action,
   input  logic         expire,
   output logic         rst_req,
   output logic         irq,
   output logic         flag
);

   wdog_action_e action;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         action  <= ACT_IRQ;
         rst_req <= 1'b0;
         irq     <= 1'b0;
         flag    <= 1'b0;
      end else begin
         if (load) action <= load_action;
         rst_req <= expire && (action == ACT_RESET);
         irq     <= expire && (action == ACT_IRQ);
         if (load)
            flag <= 1'b0;
         else if (expire && (action == ACT_IRQ))
            flag <= 1'b1;
      end
   end

   // R6
   exclusive_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq && rst_req));

   // R6
   rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   // R7
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R7
   flag_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> irq);

   // R3
   write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !flag);

endmodule

// File: rtl/wdog_prescaled.sv
module wdog_prescaled
   import wdog_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int MULT_W    = 5,
   parameter int RES_W     = 2,
   parameter int CNT_W     = 12,
   parameter bit USE_SHIFT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              tick,
   output logic              sys_rst_req,
   output logic              wdt_irq,
   output logic              expired_flag
);

   localparam int  MULT_LSB  = RES_W;
   localparam int  STEER_BIT = RES_W + MULT_W;
   localparam int  MAX_SHIFT = 2 * ((1 << RES_W) - 1);
   localparam longint MAX_TICKS = longint'((1 << MULT_W) - 1) << MAX_SHIFT;

   generate
      if (STEER_BIT != DATA_W - 1) begin : g_bad_layout
         $error("steering bit must be the top bit of the code byte");
      end
      if (MAX_TICKS >= (longint'(1) << CNT_W)) begin : g_bad_cnt
         $error("CNT_W too narrow for the largest coded interval");
      end
   endgenerate

   logic [MULT_W-1:0] code_mult;
   logic [RES_W-1:0]  code_res;
   logic [CNT_W-1:0]  code_ticks;
   logic              code_zero;
   logic              fire;
   logic              armed;
   wdog_action_e      code_action;

   assign code_res    = cfg_wdata[RES_W-1:0];
   assign code_mult   = cfg_wdata[MULT_LSB +: MULT_W];
   assign code_action = wdog_action_e'(cfg_wdata[STEER_BIT]);

   wdog_interval_decode #(
      .MULT_W   (MULT_W),
      .RES_W    (RES_W),
      .CNT_W    (CNT_W),
      .USE_SHIFT(USE_SHIFT)
   ) u_decode (
      .mult   (code_mult),
      .res    (code_res),
      .ticks  (code_ticks),
      .is_zero(code_zero)
   );

   wdog_countdown #(
      .CNT_W(CNT_W)
   ) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (cfg_we),
      .load_val(code_ticks),
      .load_arm(!code_zero),
      .tick    (tick),
      .expire  (fire),
      .armed   (armed)
   );

   wdog_expiry_route u_route (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (cfg_we),
      .load_action(code_action),
      .expire     (fire),
      .rst_req    (sys_rst_req),
      .irq        (wdt_irq),
      .flag       (expired_flag)
   );

   // R4
   zero_code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && (cfg_wdata[STEER_BIT-1:MULT_LSB] == '0)) |=> !armed);

   // R10
   write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |-> !fire);

endmodule

// File: tb/wdog_prescaled_bench.sv
module wdog_prescaled_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic       tick = 1'b0;
   logic       sys_rst_req;
   logic       wdt_irq;
   logic       expired_flag;

   int n_run = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   wdog_prescaled u_wdog_prescaled (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_we      (cfg_we),
      .cfg_wdata   (cfg_wdata),
      .tick        (tick),
      .sys_rst_req (sys_rst_req),
      .wdt_irq     (wdt_irq),
      .expired_flag(expired_flag)
   );

   function automatic int exp_ticks(input logic [7:0] code);
      return int'(code[6:2]) * (1 << (2 * int'(code[1:0])));
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [2:0] act, input logic [2:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: {rst_req,irq,flag} actual=%b expected=%b",
                  req, what, act, exp);
      end
   endtask

   function automatic logic [2:0] outs();
      return {sys_rst_req, wdt_irq, expired_flag};
   endfunction

   task automatic wr(input logic [7:0] v, input logic with_tick);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = v; tick = with_tick;
      @(negedge clk);
      cfg_we = 1'b0; tick = 1'b0;
   endtask

   task automatic one_tick();
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
   endtask

   // issue n ticks; return 1 if any output pulse showed up
   task automatic ticks_quiet(input int n, output bit saw);
      saw = 0;
      for (int i = 0; i < n; i++) begin
         one_tick();
         if (sys_rst_req || wdt_irq) saw = 1;
      end
   endtask

   task automatic t_reset();
      chk("R1", "after reset", outs(), 3'b000);
      begin
         bit saw;
         ticks_quiet(20, saw);
         chk("R1", "ticks with no arming", {1'b0, saw, 1'b0}, 3'b000);
      end
   endtask

   task automatic t_interval(input logic [7:0] code);
      int n;
      bit saw;
      n = exp_ticks(code);
      wr(code, 1'b0);
      chk("R3", "flag after write", {2'b00, expired_flag}, 3'b000);
      ticks_quiet(n - 1, saw);
      chk("R2", $sformatf("no early pulse code %h", code), {1'b0, saw, 1'b0}, 3'b000);
      one_tick();
      chk("R2", $sformatf("pulse on tick %0d code %h", n, code), outs(), 3'b011);
      @(negedge clk);
      chk("R7", "irq one cycle, flag held", outs(), 3'b001);
      ticks_quiet(10, saw);
      chk("R8", "no re-fire after expiry", {1'b0, saw, expired_flag}, 3'b001);
   endtask

   task automatic t_reset_mode();
      bit saw;
      wr(8'h88, 1'b0);               // mult 2, res 0, reset mode
      chk("R3", "flag cleared by write", {2'b00, expired_flag}, 3'b000);
      ticks_quiet(1, saw);
      chk("R6", "no early reset", {1'b0, saw, 1'b0}, 3'b000);
      one_tick();
      chk("R6", "reset request pulse", outs(), 3'b100);
      @(negedge clk);
      chk("R6", "reset request one cycle", outs(), 3'b000);
   endtask

   task automatic t_disarm(input logic [7:0] code);
      bit saw;
      wr(code, 1'b0);
      ticks_quiet(100, saw);
      chk("R4", $sformatf("zero multiplier code %h", code), {1'b0, saw, expired_flag}, 3'b000);
   endtask

   task automatic t_restart();
      bit saw;
      wr(8'h28, 1'b0);               // 10 ticks
      ticks_quiet(7, saw);
      wr(8'h0C, 1'b0);               // 3 ticks
      ticks_quiet(2, saw);
      chk("R5", "old count discarded", {1'b0, saw, 1'b0}, 3'b000);
      one_tick();
      chk("R5", "fires on new interval", outs(), 3'b011);
      wr(8'h00, 1'b0);
      chk("R3", "write clears flag", outs(), 3'b000);
   endtask

   task automatic t_no_tick();
      bit saw;
      wr(8'h08, 1'b0);               // 2 ticks
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (wdt_irq || sys_rst_req) saw = 1;
      end
      chk("R9", "idle cycles do not count", {1'b0, saw, 1'b0}, 3'b000);
      ticks_quiet(1, saw);
      chk("R9", "first tick quiet", {1'b0, saw, 1'b0}, 3'b000);
      one_tick();
      chk("R9", "fires after 2 ticks", outs(), 3'b011);
   endtask

   task automatic t_collision();
      bit saw;
      wr(8'h08, 1'b1);               // 2 ticks, tick on write cycle
      ticks_quiet(1, saw);
      chk("R10", "tick on write not counted", {1'b0, saw, expired_flag}, 3'b000);
      one_tick();
      chk("R10", "fires on 2nd later tick", outs(), 3'b011);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_interval(8'h0C);             // 3 * 1
      t_interval(8'h05);             // 1 * 4
      t_interval(8'h0A);             // 2 * 16
      t_interval(8'h7F);             // 31 * 64
      t_reset_mode();
      t_disarm(8'h00);
      t_disarm(8'h03);
      t_restart();
      t_no_tick();
      t_collision();
      // R1: reset mid-countdown stops it and clears the flag
      begin
         bit saw;
         wr(8'h08, 1'b0);
         @(negedge clk); rst_n = 1'b0;
         @(negedge clk); rst_n = 1'b1;
         chk("R1", "reset clears flag", outs(), 3'b000);
         ticks_quiet(5, saw);
         chk("R1", "reset stops countdown", {1'b0, saw, 1'b0}, 3'b000);
      end
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule